// File: doc/BRIEF.md
# Serial Port Sample-Rate Clock Generator

This block makes the data bit clock for a buffered serial port. It picks one of four candidate input clocks: an internal reference or one of three external clock pins. For each pin, a polarity control decides which edge counts as the active one. It divides the chosen clock by a programmable ratio from 1 to 256 and keeps the output at an even duty cycle. Alongside the bit clock it gives a one-cycle tick at the start of every output period, which later frame-sync stages use to advance.

All logic runs on one system clock. The four candidate inputs are resynchronised into that domain. Their edges become event strobes, and a half-period counter turns those strobes into the output. Configuration arrives through a register-style write port. The generator comes out of reset held idle and stays idle until software sets the run bit. A change to the ratio or the source is stored at once but takes effect only at the next period boundary.

Top module: `srg_clkgen`

## Requirements
- R1: After the asynchronous reset, `clkg_o` and `clkg_tick_o` are 0. The readbacks `run_o` and `sync_mode_o` are also 0, so the generator stays idle until software writes the run bit to 1.
- R2: While the run bit is 0, `clkg_o` stays low and `clkg_tick_o` never pulses, however the candidate inputs toggle.
- R3: The source is chosen by `{cfg_src_hi_i, cfg_src_lo_i}`: 00 selects `pin_clks_i`, 01 selects `ref_clk_i`, 10 selects `pin_clkr_i` and 11 selects `pin_clkx_i`.
- R4: A pin's polarity bit set to 0 makes its rising edge the active edge, and set to 1 makes its falling edge the active edge. The internal reference always uses its rising edge. Each `clkg_o` period starts on an active edge. With a divide field of 0, `clkg_o` follows the selected pin, or its inverse when the polarity bit is 1.
- R5: With divide field value V, `clkg_o` has a period of V+1 input periods. Its high and low phases are each exactly (V+1) input half-periods, for both odd and even ratios, across the range V = 0 to 255.
- R6: `clkg_tick_o` is high for exactly one cycle per `clkg_o` period, in the cycle in which `clkg_o` rises, and at no other time.
- R7: A write that changes the divide field or the source select while the generator runs leaves the current `clkg_o` period unchanged. The new values govern from the next rising edge of `clkg_o` onward.
- R8: `sync_mode_o` and `run_o` show the sync-mode bit and the run bit from the most recent write, starting in the cycle after `cfg_we_i`.
- R9: Toggling a candidate input that is not selected has no effect on `clkg_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Write strobe for the configuration fields |
| cfg_div_i | input | 8 | Divide field; ratio is value + 1 |
| cfg_src_hi_i | input | 1 | Upper source-select bit |
| cfg_src_lo_i | input | 1 | Lower source-select bit |
| cfg_pol_s_i | input | 1 | Active-edge polarity for pin_clks_i |
| cfg_pol_x_i | input | 1 | Active-edge polarity for pin_clkx_i |
| cfg_pol_r_i | input | 1 | Active-edge polarity for pin_clkr_i |
| cfg_sync_i | input | 1 | Sync-mode bit, stored and exposed only |
| cfg_run_i | input | 1 | Run bit; 0 holds the generator in reset |
| ref_clk_i | input | 1 | Internal reference clock, sampled |
| pin_clks_i | input | 1 | External clock pin S |
| pin_clkx_i | input | 1 | External clock pin X |
| pin_clkr_i | input | 1 | External clock pin R |
| clkg_o | output | 1 | Divided data bit clock |
| clkg_tick_o | output | 1 | One-cycle pulse at each rising edge of clkg_o |
| sync_mode_o | output | 1 | Stored sync-mode bit |
| run_o | output | 1 | Stored run bit |

## Verification
Each source is driven with its own half-period, so measured high and low lengths show which input the divider follows. The ratio is exercised with 1, 2, 3, 4 and 256. The odd values show whether the inactive edge is used to keep the phases equal, and the extremes cover the pass-through case and the full counter. Polarity is told apart by sampling the selected pin in the cycle `clkg_o` rises. Deferred reconfiguration is told apart from immediate reconfiguration by comparing the period that contains the write with the period after it, while unselected pins toggle at a different rate throughout.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_PIN_S = 2'd0,
    SRC_REF   = 2'd1,
    SRC_PIN_R = 2'd2,
    SRC_PIN_X = 2'd3
  } srg_src_e;
endpackage

// File: rtl/srg_rst_sync.sv
module srg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/srg_edge_sel.sv
module srg_edge_sel #(
  parameter int N      = 4,
  parameter int SYNC   = 2,
  localparam int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     raw_i,
  input  logic [N-1:0]     pol_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             act_o,
  output logic             opp_o
);
  logic [N-1:0] sampled;
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] fall;

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [SYNC-1:0] chain_q;
    logic [SYNC-1:0] chain_d;

    always_comb chain_d = {chain_q[SYNC-2:0], raw_i[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sampled[i] = chain_q[SYNC-1];
    assign rise[i]    = sampled[i] & ~prev_q[i];
    assign fall[i]    = ~sampled[i] & prev_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sampled;
  end

  always_comb begin
    act_o = pol_i[sel_i] ? fall[sel_i] : rise[sel_i];
    opp_o = pol_i[sel_i] ? rise[sel_i] : fall[sel_i];
  end

  AST_ONE_EDGE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, opp_o})); // R4
endmodule

// File: rtl/srg_divider.sv
module srg_divider #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             act_i,
  input  logic             opp_i,
  input  logic [DIV_W-1:0] div_req_i,
  input  logic [SEL_W-1:0] sel_req_i,
  output logic [SEL_W-1:0] sel_act_o,
  output logic             clkg_o,
  output logic             tick_o
);
  logic             running_q, running_d;
  logic             clkg_q, clkg_d;
  logic             tick_q, tick_d;
  logic [DIV_W-1:0] hcnt_q, hcnt_d;
  logic [DIV_W-1:0] div_act_q, div_act_d;
  logic [SEL_W-1:0] sel_act_q, sel_act_d;

  always_comb begin
    running_d = running_q;
    clkg_d    = clkg_q;
    tick_d    = 1'b0;
    hcnt_d    = hcnt_q;
    div_act_d = div_act_q;
    sel_act_d = sel_act_q;
    if (!run_i) begin
      running_d = 1'b0;
      clkg_d    = 1'b0;
      hcnt_d    = div_req_i;
      div_act_d = div_req_i;
      sel_act_d = sel_req_i;
    end else if (!running_q) begin
      hcnt_d    = div_req_i;
      div_act_d = div_req_i;
      sel_act_d = sel_req_i;
      if (act_i) begin
        running_d = 1'b1;
        clkg_d    = 1'b1;
        tick_d    = 1'b1;
      end
    end else if (act_i || opp_i) begin
      if (hcnt_q == '0) begin
        clkg_d = ~clkg_q;
        if (!clkg_q) begin
          tick_d    = 1'b1;
          div_act_d = div_req_i;
          sel_act_d = sel_req_i;
          hcnt_d    = div_req_i;
        end else begin
          hcnt_d = div_act_q;
        end
      end else begin
        hcnt_d = hcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      clkg_q    <= 1'b0;
      tick_q    <= 1'b0;
      hcnt_q    <= '0;
      div_act_q <= '0;
      sel_act_q <= '0;
    end else begin
      running_q <= running_d;
      clkg_q    <= clkg_d;
      tick_q    <= tick_d;
      hcnt_q    <= hcnt_d;
      div_act_q <= div_act_d;
      sel_act_q <= sel_act_d;
    end
  end

  assign sel_act_o = sel_act_q;
  assign clkg_o    = clkg_q;
  assign tick_o    = tick_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!clkg_q && !tick_q)); // R2
  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkg_q) |-> tick_q); // R6
  AST_TICK_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (clkg_q && !$past(clkg_q))); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && $past(running_q) && !tick_q) |->
      ($stable(div_act_q) && $stable(sel_act_q))); // R7
  AST_TOGGLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && !$stable(clkg_q)) |-> $past(act_i || opp_i)); // R5
endmodule

// File: rtl/srg_clkgen.sv
module srg_clkgen
  import srg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_src_hi_i,
  input  logic             cfg_src_lo_i,
  input  logic             cfg_pol_s_i,
  input  logic             cfg_pol_x_i,
  input  logic             cfg_pol_r_i,
  input  logic             cfg_sync_i,
  input  logic             cfg_run_i,
  input  logic             ref_clk_i,
  input  logic             pin_clks_i,
  input  logic             pin_clkx_i,
  input  logic             pin_clkr_i,
  output logic             clkg_o,
  output logic             clkg_tick_o,
  output logic             sync_mode_o,
  output logic             run_o
);
  logic rst_n_s;

  logic [DIV_W-1:0]   div_q, div_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [2:0]         pol_q, pol_d;
  logic               sync_q, sync_d;
  logic               run_q, run_d;

  logic [NUM_SRC-1:0] raw_vec;
  logic [NUM_SRC-1:0] pol_vec;
  logic [SEL_W-1:0]   sel_act;
  logic               act_evt;
  logic               opp_evt;

  srg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  always_comb begin
    div_d  = div_q;
    sel_d  = sel_q;
    pol_d  = pol_q;
    sync_d = sync_q;
    run_d  = run_q;
    if (cfg_we_i) begin
      div_d  = cfg_div_i;
      sel_d  = {cfg_src_hi_i, cfg_src_lo_i};
      pol_d  = {cfg_pol_x_i, cfg_pol_r_i, cfg_pol_s_i};
      sync_d = cfg_sync_i;
      run_d  = cfg_run_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      div_q  <= '0;
      sel_q  <= '0;
      pol_q  <= '0;
      sync_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      sel_q  <= sel_d;
      pol_q  <= pol_d;
      sync_q <= sync_d;
      run_q  <= run_d;
    end
  end

  always_comb begin
    raw_vec            = '0;
    pol_vec            = '0;
    raw_vec[SRC_PIN_S] = pin_clks_i;
    raw_vec[SRC_REF]   = ref_clk_i;
    raw_vec[SRC_PIN_R] = pin_clkr_i;
    raw_vec[SRC_PIN_X] = pin_clkx_i;
    pol_vec[SRC_PIN_S] = pol_q[0];
    pol_vec[SRC_REF]   = 1'b0;
    pol_vec[SRC_PIN_R] = pol_q[1];
    pol_vec[SRC_PIN_X] = pol_q[2];
  end

  srg_edge_sel #(.N(NUM_SRC), .SYNC(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .raw_i (raw_vec),
    .pol_i (pol_vec),
    .sel_i (sel_act),
    .act_o (act_evt),
    .opp_o (opp_evt)
  );

  srg_divider #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_i     (run_q),
    .act_i     (act_evt),
    .opp_i     (opp_evt),
    .div_req_i (div_q),
    .sel_req_i (sel_q),
    .sel_act_o (sel_act),
    .clkg_o    (clkg_o),
    .tick_o    (clkg_tick_o)
  );

  assign sync_mode_o = sync_q;
  assign run_o       = run_q;

  AST_SYNC_READBACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(cfg_we_i) |-> (sync_mode_o == $past(cfg_sync_i))); // R8
  AST_RUN_READBACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(cfg_we_i) |-> (run_o == $past(cfg_run_i))); // R8
endmodule

// File: tb/srg_clkgen_tb.sv
`timescale 1ns/1ps
module srg_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [1:0] cfg_sel = '0;
  logic [2:0] cfg_pol = '0;
  logic       cfg_sync = 1'b0;
  logic       cfg_run = 1'b0;
  logic [3:0] pins = '0;
  logic       clkg, tick, sync_mode, run;

  int n_tests = 0;
  int n_fail  = 0;
  int half [4];
  int pcnt [4];

  logic prev_g;
  int   run_len, hi_len, lo_len, rises, ticks, tick_err;
  logic pin_at_rise;

  always #2.5 clk = ~clk;

  srg_clkgen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_div_i    (cfg_div),
    .cfg_src_hi_i (cfg_sel[1]),
    .cfg_src_lo_i (cfg_sel[0]),
    .cfg_pol_s_i  (cfg_pol[0]),
    .cfg_pol_x_i  (cfg_pol[2]),
    .cfg_pol_r_i  (cfg_pol[1]),
    .cfg_sync_i   (cfg_sync),
    .cfg_run_i    (cfg_run),
    .ref_clk_i    (pins[1]),
    .pin_clks_i   (pins[0]),
    .pin_clkx_i   (pins[3]),
    .pin_clkr_i   (pins[2]),
    .clkg_o       (clkg),
    .clkg_tick_o  (tick),
    .sync_mode_o  (sync_mode),
    .run_o        (run)
  );

  // pin index: 0 = S, 1 = internal reference, 2 = R, 3 = X (same as select code)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (half[i] != 0) begin
          if (pcnt[i] >= half[i] - 1) begin
            pins[i] <= ~pins[i];
            pcnt[i] <= 0;
          end else begin
            pcnt[i] <= pcnt[i] + 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_g <= 1'b0; run_len <= 0; hi_len <= 0; lo_len <= 0;
      rises <= 0; ticks <= 0; tick_err <= 0; pin_at_rise <= 1'b0;
    end else begin
      if (tick) ticks <= ticks + 1;
      if (tick != (clkg && !prev_g)) tick_err <= tick_err + 1;
      if (clkg == prev_g) begin
        run_len <= run_len + 1;
      end else begin
        if (prev_g) hi_len <= run_len; else lo_len <= run_len;
        run_len <= 1;
        if (clkg) begin
          rises <= rises + 1;
          pin_at_rise <= pins[cfg_sel];
        end
      end
      prev_g <= clkg;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d, input logic [1:0] s,
                           input logic [2:0] p, input logic sy, input logic rn);
    @(negedge clk);
    cfg_div = d; cfg_sel = s; cfg_pol = p; cfg_sync = sy; cfg_run = rn;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rises(input int n);
    int target;
    target = rises + n;
    wait (rises >= target);
    @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] d, input logic [1:0] s, input logic [2:0] p);
    cfg_write(d, s, p, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    cfg_write(d, s, p, 1'b0, 1'b1);
  endtask

  task automatic expect_period(input int exp_half, input string req);
    wait_rises(3);
    check(hi_len == exp_half, req, "high length", hi_len, exp_half);
    check(lo_len == exp_half, req, "low length", lo_len, exp_half);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(clkg == 1'b0, "R1", "clkg after reset", clkg, 0);
    check(tick == 1'b0, "R1", "tick after reset", tick, 0);
    check(run == 1'b0, "R1", "run readback after reset", run, 0);
    check(sync_mode == 1'b0, "R1", "sync readback after reset", sync_mode, 0);
  endtask

  task automatic t_held;
    int bad;
    bad = 0;
    half[0] = 2; half[1] = 3; half[2] = 4; half[3] = 5;
    cfg_write(8'd0, 2'b01, 3'b000, 1'b0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clkg || tick) bad++;
    end
    check(bad == 0, "R2", "cycles with clkg/tick active while idle", bad, 0);
    check(rises == 0, "R2", "rises while idle", rises, 0);
  endtask

  task automatic t_sources;
    half[0] = 2; half[1] = 5; half[2] = 4; half[3] = 3;
    restart(8'd1, 2'b00, 3'b000); expect_period(4,  "R3");
    restart(8'd1, 2'b01, 3'b000); expect_period(10, "R3");
    restart(8'd1, 2'b10, 3'b000); expect_period(8,  "R3");
    restart(8'd1, 2'b11, 3'b000); expect_period(6,  "R3");
  endtask

  task automatic t_polarity;
    half[0] = 2; half[1] = 2; half[2] = 2; half[3] = 6;
    restart(8'd0, 2'b11, 3'b000);
    expect_period(6, "R4");
    check(pin_at_rise == 1'b1, "R4", "pin level at clkg rise, rising active", pin_at_rise, 1);
    restart(8'd0, 2'b11, 3'b100);
    expect_period(6, "R4");
    check(pin_at_rise == 1'b0, "R4", "pin level at clkg rise, falling active", pin_at_rise, 0);
  endtask

  task automatic t_ratios;
    half[0] = 2; half[1] = 2; half[2] = 3; half[3] = 5;
    restart(8'd0,   2'b01, 3'b000); expect_period(2,   "R5");
    restart(8'd1,   2'b01, 3'b000); expect_period(4,   "R5");
    restart(8'd2,   2'b01, 3'b000); expect_period(6,   "R5");
    restart(8'd3,   2'b01, 3'b000); expect_period(8,   "R5");
    restart(8'd255, 2'b01, 3'b000); expect_period(512, "R5");
  endtask

  task automatic t_tick;
    int r0, k0;
    half[1] = 3;
    restart(8'd2, 2'b01, 3'b000);
    wait_rises(1);
    r0 = rises; k0 = ticks;
    wait_rises(4);
    check((ticks - k0) == (rises - r0), "R6", "ticks per rises", ticks - k0, rises - r0);
    check(tick_err == 0, "R6", "tick not aligned with clkg rise", tick_err, 0);
  endtask

  task automatic t_cfg_defer;
    half[0] = 3; half[1] = 2; half[2] = 2; half[3] = 2;
    restart(8'd3, 2'b00, 3'b000);
    wait_rises(3);
    cfg_write(8'd1, 2'b00, 3'b000, 1'b0, 1'b1);
    wait_rises(1);
    check(hi_len == 12, "R7", "high length of period holding the write", hi_len, 12);
    check(lo_len == 12, "R7", "low length of period holding the write", lo_len, 12);
    wait_rises(1);
    check(hi_len == 6, "R7", "high length after next rise", hi_len, 6);
    check(lo_len == 6, "R7", "low length after next rise", lo_len, 6);
  endtask

  task automatic t_status;
    cfg_write(8'd1, 2'b00, 3'b000, 1'b1, 1'b1);
    check(sync_mode == 1'b1, "R8", "sync readback set", sync_mode, 1);
    check(run == 1'b1, "R8", "run readback set", run, 1);
    cfg_write(8'd1, 2'b00, 3'b000, 1'b0, 1'b0);
    check(sync_mode == 1'b0, "R8", "sync readback cleared", sync_mode, 0);
    check(run == 1'b0, "R8", "run readback cleared", run, 0);
  endtask

  task automatic t_ignore;
    half[0] = 2; half[1] = 3; half[2] = 2; half[3] = 7;
    restart(8'd1, 2'b11, 3'b000);
    expect_period(14, "R9");
    half[0] = 4; half[2] = 5; half[1] = 2;
    expect_period(14, "R9");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin half[i] = 0; pcnt[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_held;
    t_status;
    t_sources;
    t_polarity;
    t_ratios;
    t_tick;
    t_cfg_defer;
    t_ignore;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule